// File: doc/BRIEF.md
# Transceiver Register Bank with Set and Clear Aliases

This block is the byte-wide register bank of a USB transceiver. The transceiver reaches it through register-write and register-read commands from the link controller. The bank holds four read-only identification bytes and eight writable control registers:

- function control
- interface control
- OTG control
- rising-edge interrupt enable
- falling-edge interrupt enable
- scratch
- carkit control
- power control

It also has one read-only debug byte, which shows live state from elsewhere in the transceiver. Command parsing, bus turnaround and the analog effect of each control bit are handled outside this block.

Every writable control register answers at three consecutive addresses. The base address replaces the register contents. The next address ORs the written byte into the register. The one after that clears the bits that are set in the written byte. Software can therefore change single bits in one access, with no read-modify-write. Reads from any of the three addresses return the current contents. Reads are combinational from the address. Writes take effect on the rising clock edge where `wr_en` is high. Reset is synchronous and active high.

Top module: `ulpi_regbank`

## Requirements
- R1: While `rst` is high, a clock edge loads the reset values: function control 41h, interface control 00h, OTG control 06h, both interrupt-enable registers 1Fh, and scratch, carkit control and power control all 00h.
- R2: Each control register has a base address: function control 04h, interface control 07h, OTG control 0Ah, rising enable 0Dh, falling enable 10h, scratch 16h, carkit control 19h, power control 3Dh. A write to the base address stores the data byte, limited to the register's implemented bits. The change appears on the matching output port after that clock edge.
- R3: A write to base+1 ORs the data byte into the register. Bits that are zero in the data byte keep their value.
- R4: A write to base+2 clears every register bit that is 1 in the data byte. All other bits keep their value.
- R5: A read from base, base+1 or base+2 returns the current register contents on `rd_data`. This value equals the register's output port.
- R6: Addresses 00h to 03h read the constants 6Bh, 3Ah, 2Eh and 0Ah: vendor identity low byte, vendor identity high byte, product identity low byte, product identity high byte. Writes to these addresses change no register.
- R7: Address 15h reads the value on `dbg_i`. A write to 15h changes no register.
- R8: Reads from 13h, 14h and 1Ch to 3Ch return 00h. Writes to these addresses change no register.
- R9: Reserved bits always read 0 and cannot be set by a write or a set access. OTG control bit 5 is reserved. Bits 7 to 5 of both interrupt-enable registers are reserved.
- R10: A control register changes only on a clock edge with `wr_en` high and an address inside its own three-address window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | 6 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe for the current address |
| wr_data | input | 8 | Write data byte |
| dbg_i | input | 8 | Live debug byte shown at address 15h |
| rd_data | output | 8 | Read data for `acc_addr` |
| func_ctl_o | output | 8 | Function control register |
| intf_ctl_o | output | 8 | Interface control register |
| otg_ctl_o | output | 8 | OTG control register |
| rise_en_o | output | 8 | Rising-edge interrupt enable register |
| fall_en_o | output | 8 | Falling-edge interrupt enable register |
| carkit_ctl_o | output | 8 | Carkit control register |
| pwr_ctl_o | output | 8 | Power control register |

## Verification
The hardest case to reach from the ports is a set or write access that targets a reserved bit. It matters only when a register is both partly implemented and driven through an alias. The bench therefore sends the same byte patterns (all ones, alternating bits, single bits) through all three aliases of every register, including the partly implemented ones. After each access it compares the output port and a read at every alias against its own masked model. The bench also writes FFh to every address that is not a control register, then sweeps all 64 addresses again. This shows that none of those writes reached a control register.

// File: rtl/ulpi_regbank_pkg.sv
package ulpi_regbank_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 8;
    localparam int NCTL   = 8;
    localparam int NID    = 4;
    localparam int IDX_W  = $clog2(NCTL);

    localparam logic [15:0] VENDOR_WORD  = 16'h3A6B;
    localparam logic [15:0] PRODUCT_WORD = 16'h0A2E;
    localparam logic [ADDR_W-1:0] DBG_ADDR = 6'h15;

    localparam int CTL_FUNC   = 0;
    localparam int CTL_INTF   = 1;
    localparam int CTL_OTG    = 2;
    localparam int CTL_RISE   = 3;
    localparam int CTL_FALL   = 4;
    localparam int CTL_SCR    = 5;
    localparam int CTL_CARKIT = 6;
    localparam int CTL_PWR    = 7;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2
    } acc_op_e;

    typedef struct packed {
        logic             ctl_hit;
        logic [IDX_W-1:0] ctl_idx;
        acc_op_e          op;
        logic             id_hit;
        logic [1:0]       id_idx;
        logic             dbg_hit;
    } dec_t;

    function automatic logic [ADDR_W-1:0] ctl_base(input int i);
        case (i)
            CTL_FUNC:   return 6'h04;
            CTL_INTF:   return 6'h07;
            CTL_OTG:    return 6'h0A;
            CTL_RISE:   return 6'h0D;
            CTL_FALL:   return 6'h10;
            CTL_SCR:    return 6'h16;
            CTL_CARKIT: return 6'h19;
            default:    return 6'h3D;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ctl_reset(input int i);
        case (i)
            CTL_FUNC:           return 8'h41;
            CTL_OTG:            return 8'h06;
            CTL_RISE, CTL_FALL: return 8'h1F;
            default:            return 8'h00;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] ctl_mask(input int i);
        case (i)
            CTL_OTG:            return 8'hDF;
            CTL_RISE, CTL_FALL: return 8'h1F;
            default:            return 8'hFF;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] id_byte(input logic [1:0] k);
        case (k)
            2'd0:    return VENDOR_WORD[7:0];
            2'd1:    return VENDOR_WORD[15:8];
            2'd2:    return PRODUCT_WORD[7:0];
            default: return PRODUCT_WORD[15:8];
        endcase
    endfunction

endpackage

// File: rtl/ulpi_regbank_decode.sv
module ulpi_regbank_decode
    import ulpi_regbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb begin
        dec         = '0;
        dec.op      = OP_WRITE;
        for (int i = 0; i < NCTL; i++) begin
            if (int'(addr) >= int'(ctl_base(i)) && int'(addr) <= int'(ctl_base(i)) + 2) begin
                dec.ctl_hit = 1'b1;
                dec.ctl_idx = IDX_W'(i);
                dec.op      = acc_op_e'(2'(int'(addr) - int'(ctl_base(i))));
            end
        end
        if (int'(addr) < NID) begin
            dec.id_hit = 1'b1;
            dec.id_idx = addr[1:0];
        end
        dec.dbg_hit = (addr == DBG_ADDR);
    end
endmodule

// File: rtl/ulpi_regbank_cell.sv
module ulpi_regbank_cell
    import ulpi_regbank_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_VAL = '0,
    parameter logic [DATA_W-1:0] MASK    = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  acc_op_e           op,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (we) begin
            case (op)
                OP_WRITE: q <= d & MASK;
                OP_SET:   q <= (q | d) & MASK;
                OP_CLEAR: q <= q & ~d & MASK;
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/ulpi_regbank_rdmux.sv
module ulpi_regbank_rdmux
    import ulpi_regbank_pkg::*;
(
    input  dec_t                         dec,
    input  logic [NCTL-1:0][DATA_W-1:0]  ctl_q,
    input  logic [DATA_W-1:0]            dbg_i,
    output logic [DATA_W-1:0]            rd_data
);
    always_comb begin
        rd_data = '0;
        if (dec.ctl_hit)
            rd_data = ctl_q[dec.ctl_idx];
        else if (dec.id_hit)
            rd_data = id_byte(dec.id_idx);
        else if (dec.dbg_hit)
            rd_data = dbg_i;
    end
endmodule

// File: rtl/ulpi_regbank.sv
module ulpi_regbank
    import ulpi_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        acc_addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        dbg_i,
    output logic [7:0]        rd_data,
    output logic [7:0]        func_ctl_o,
    output logic [7:0]        intf_ctl_o,
    output logic [7:0]        otg_ctl_o,
    output logic [7:0]        rise_en_o,
    output logic [7:0]        fall_en_o,
    output logic [7:0]        carkit_ctl_o,
    output logic [7:0]        pwr_ctl_o
);
    dec_t                        dec;
    logic [NCTL-1:0][DATA_W-1:0] ctl_q;

    ulpi_regbank_decode u_dec (
        .addr (acc_addr),
        .dec  (dec)
    );

    for (genvar g = 0; g < NCTL; g++) begin : g_ctl
        ulpi_regbank_cell #(
            .RST_VAL (ctl_reset(g)),
            .MASK    (ctl_mask(g))
        ) u_cell (
            .clk (clk),
            .rst (rst),
            .we  (wr_en && dec.ctl_hit && (dec.ctl_idx == IDX_W'(g))),
            .op  (dec.op),
            .d   (wr_data),
            .q   (ctl_q[g])
        );
    end

    ulpi_regbank_rdmux u_rd (
        .dec     (dec),
        .ctl_q   (ctl_q),
        .dbg_i   (dbg_i),
        .rd_data (rd_data)
    );

    // scratch (CTL_SCR) is reachable only through the read path
    assign func_ctl_o   = ctl_q[CTL_FUNC];
    assign intf_ctl_o   = ctl_q[CTL_INTF];
    assign otg_ctl_o    = ctl_q[CTL_OTG];
    assign rise_en_o    = ctl_q[CTL_RISE];
    assign fall_en_o    = ctl_q[CTL_FALL];
    assign carkit_ctl_o = ctl_q[CTL_CARKIT];
    assign pwr_ctl_o    = ctl_q[CTL_PWR];
endmodule

// File: rtl/ulpi_regbank_chk.sv
module ulpi_regbank_chk (
    input logic       clk,
    input logic       rst,
    input logic [5:0] acc_addr,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] dbg_i,
    input logic [7:0] rd_data,
    input logic [7:0] func_ctl_o,
    input logic [7:0] intf_ctl_o,
    input logic [7:0] otg_ctl_o,
    input logic [7:0] rise_en_o,
    input logic [7:0] fall_en_o,
    input logic [7:0] carkit_ctl_o,
    input logic [7:0] pwr_ctl_o
);
    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (func_ctl_o == 8'h41 && otg_ctl_o == 8'h06 && rise_en_o == 8'h1F
                 && intf_ctl_o == 8'h00 && pwr_ctl_o == 8'h00));

    p_plain_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc_addr == 6'h04) |=> func_ctl_o == $past(wr_data));

    p_set_alias_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc_addr == 6'h0B) |=> otg_ctl_o == (($past(otg_ctl_o) | $past(wr_data)) & 8'hDF));

    p_clear_alias_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && acc_addr == 6'h09) |=> intf_ctl_o == ($past(intf_ctl_o) & ~$past(wr_data)));

    p_alias_read_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_addr == 6'h3F) |-> rd_data == pwr_ctl_o);

    p_id_read_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_addr == 6'h01) |-> rd_data == 8'h3A);

    p_dbg_read_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_addr == 6'h15) |-> rd_data == dbg_i);

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_addr >= 6'h1C && acc_addr <= 6'h3C) |-> rd_data == 8'h00);

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (otg_ctl_o[5] == 1'b0 && rise_en_o[7:5] == 3'b000 && fall_en_o[7:5] == 3'b000));

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(func_ctl_o) && $stable(otg_ctl_o) && $stable(carkit_ctl_o)
                    && $stable(fall_en_o)));
endmodule

bind ulpi_regbank ulpi_regbank_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .acc_addr     (acc_addr),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .dbg_i        (dbg_i),
    .rd_data      (rd_data),
    .func_ctl_o   (func_ctl_o),
    .intf_ctl_o   (intf_ctl_o),
    .otg_ctl_o    (otg_ctl_o),
    .rise_en_o    (rise_en_o),
    .fall_en_o    (fall_en_o),
    .carkit_ctl_o (carkit_ctl_o),
    .pwr_ctl_o    (pwr_ctl_o)
);

// File: tb/ulpi_regbank_tb_top.sv
module ulpi_regbank_tb_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] acc_addr;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] dbg_i;
    logic [7:0] rd_data;
    logic [7:0] func_ctl_o, intf_ctl_o, otg_ctl_o, rise_en_o, fall_en_o, carkit_ctl_o, pwr_ctl_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] model [8];
    localparam logic [5:0] BASE [8] = '{6'h04, 6'h07, 6'h0A, 6'h0D, 6'h10, 6'h16, 6'h19, 6'h3D};
    localparam logic [7:0] RSTV [8] = '{8'h41, 8'h00, 8'h06, 8'h1F, 8'h1F, 8'h00, 8'h00, 8'h00};
    localparam logic [7:0] MSK  [8] = '{8'hFF, 8'hFF, 8'hDF, 8'h1F, 8'h1F, 8'hFF, 8'hFF, 8'hFF};
    localparam logic [7:0] IDS  [4] = '{8'h6B, 8'h3A, 8'h2E, 8'h0A};

    always #(CLK_P/2) clk = ~clk;

    ulpi_regbank dut_i (
        .clk (clk), .rst (rst), .acc_addr (acc_addr), .wr_en (wr_en), .wr_data (wr_data),
        .dbg_i (dbg_i), .rd_data (rd_data), .func_ctl_o (func_ctl_o), .intf_ctl_o (intf_ctl_o),
        .otg_ctl_o (otg_ctl_o), .rise_en_o (rise_en_o), .fall_en_o (fall_en_o),
        .carkit_ctl_o (carkit_ctl_o), .pwr_ctl_o (pwr_ctl_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic int reg_of(input logic [5:0] a);
        for (int i = 0; i < 8; i++)
            if (int'(a) >= int'(BASE[i]) && int'(a) <= int'(BASE[i]) + 2) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [5:0] a);
        int r = reg_of(a);
        if (r >= 0) return model[r];
        if (a < 6'd4) return IDS[a[1:0]];
        if (a == 6'h15) return dbg_i;
        return 8'h00;
    endfunction

    function automatic logic [7:0] port_of(input int i);
        case (i)
            0: return func_ctl_o;
            1: return intf_ctl_o;
            2: return otg_ctl_o;
            3: return rise_en_o;
            4: return fall_en_o;
            6: return carkit_ctl_o;
            7: return pwr_ctl_o;
            default: return model[5];
        endcase
    endfunction

    task automatic rd_check(input logic [5:0] a, input string req);
        acc_addr = a;
        #1;
        check(req, rd_data, exp_rd(a));
    endtask

    task automatic ports_check(input string req);
        for (int i = 0; i < 8; i++)
            if (i != 5) check(req, port_of(i), model[i]);
        rd_check(BASE[5], req);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        int r;
        @(negedge clk);
        acc_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        r = reg_of(a);
        if (r >= 0) begin
            case (int'(a) - int'(BASE[r]))
                0: model[r] = d & MSK[r];
                1: model[r] = (model[r] | d) & MSK[r];
                default: model[r] = model[r] & ~d;
            endcase
        end
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 64; a++) rd_check(6'(a), req);
    endtask

    initial begin
        logic [7:0] pats [6] = '{8'hA5, 8'h5A, 8'hFF, 8'h0F, 8'h80, 8'h21};
        rst = 1'b1; wr_en = 1'b0; acc_addr = '0; wr_data = '0; dbg_i = 8'h00;
        for (int i = 0; i < 8; i++) model[i] = RSTV[i];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values and R6/R8 map at reset
        ports_check("R1");
        sweep("R1/R6/R8 reset sweep");
        // R2/R3/R4/R5/R9: each register, each alias, several patterns
        for (int r = 0; r < 8; r++) begin
            for (int p = 0; p < 6; p++) begin
                for (int op = 0; op < 3; op++) begin
                    wr(6'(int'(BASE[r]) + op), pats[(p + op) % 6]);
                    ports_check(op == 0 ? "R2 write" : (op == 1 ? "R3 set" : "R4 clear"));
                    for (int k = 0; k < 3; k++) rd_check(6'(int'(BASE[r]) + k), "R5 alias read");
                end
            end
            wr(6'(int'(BASE[r]) + 1), 8'hFF);
            check("R9 reserved after set", port_of(r), MSK[r]);
        end
        // R10: idle cycles hold everything
        repeat (5) @(negedge clk);
        ports_check("R10 hold");
        // R7 debug byte follows input
        for (int v = 0; v < 256; v += 37) begin
            dbg_i = 8'(v);
            rd_check(6'h15, "R7 debug read");
        end
        // R6/R7/R8: writes to non-control addresses change nothing
        for (int a = 0; a < 64; a++) begin
            if (reg_of(6'(a)) < 0) begin
                wr(6'(a), 8'hFF);
                ports_check("R6/R8 ignored write");
            end
        end
        sweep("R6/R7/R8 final sweep");
        // R1 again: reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = RSTV[i];
        ports_check("R1 re-reset");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule